// File: doc/BRIEF.md
# DMA Descriptor Controller Sequencer

This block runs the control side of a descriptor-based DMA engine that moves data between host memory and local memory. The host programs a small 32-bit register window with the address of a descriptor table in host memory, the index of the last valid descriptor and a direction. It then sets a start bit. The sequencer first has the read data mover copy the descriptor table into local storage. It then walks the descriptors from index zero upward and hands each one to the mover that serves the chosen direction. The read mover handles host-to-local transfers and the write mover handles local-to-host transfers.

After a mover reports that a descriptor is finished, the sequencer posts a single 32-bit completion word to host memory. It uses a write-only status port, and each direction has its own. It then raises a one-cycle interrupt request and only after that dispatches the next descriptor. The data movers, the packet layer and the descriptor storage sit outside the block. The block only tells them which descriptor index to work on and waits for their one-cycle done pulses.

Top module: `dma_desc_seq`

## Requirements
- R1: The register window has four words, selected by `csr_addr`, and reads return the selected word combinationally.
  - Word 0 is control and status. A write of bit 0 requests a start, bit 1 selects the direction (0 = host-to-local through the read mover, 1 = local-to-host through the write mover), and a one in bit 2 clears the error flag. A read returns 0 in bit 0, the direction in bit 1, the error flag in bit 2 and busy in bit 3.
  - Words 1 and 2 hold the low and high halves of the 64-bit table base address.
  - Word 3 holds the last descriptor index in its low 8 bits.
- R2: One cycle after an accepted start, `rd_cmd_valid` and `rd_cmd_fetch` are high together for exactly one cycle, asking for the table fetch. No further command follows until `rd_done` is seen.
- R3: After the fetch completes, descriptors 0 through the last index are dispatched one at a time in ascending order. Each dispatch is a one-cycle command carrying the index. It goes on the read mover (with `rd_cmd_fetch` low) when the direction is 0, or on the write mover when the direction is 1. The two command valids are never high together.
- R4: A done pulse that arrives while the block is not waiting for that particular mover has no effect.
- R5: After the active mover's done, the status port of that direction writes one word. The address is base + 0x1000 + 4 × index. The data has bit 31 set, the direction in bit 30 and the index in the low bits. The request, address and data stay stable while that port's wait-request is high. The other direction's status port stays idle.
- R6: The next descriptor is dispatched only after the status write has been accepted and the interrupt for the current descriptor has been raised.
- R7: `irq` is high for exactly one cycle per completed descriptor, in the cycle after the status write is accepted.
- R8: Busy is set from the cycle after an accepted start until the interrupt of the last descriptor. While not busy, no command, status write or interrupt is issued.
- R9: While busy, the following writes are ignored:
  - a start request, which instead sets a sticky error flag;
  - writes to the base, last-index and direction fields.

  The error flag stays set until a write of one to its clear bit.
- R10: An asynchronous active-low reset returns the block to idle with all registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_write | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word select |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for the selected word |
| table_base | output | BASE_W | Descriptor table base address given to the movers |
| rd_cmd_valid | output | 1 | One-cycle command to the read mover |
| rd_cmd_fetch | output | 1 | Marks a read-mover command as the table fetch |
| rd_cmd_index | output | IDX_W | Descriptor index for a read-mover command |
| rd_done | input | 1 | Read mover completion pulse |
| wr_cmd_valid | output | 1 | One-cycle command to the write mover |
| wr_cmd_index | output | IDX_W | Descriptor index for a write-mover command |
| wr_done | input | 1 | Write mover completion pulse |
| rd_stat_write | output | 1 | Status write request, host-to-local direction |
| rd_stat_addr | output | BASE_W | Status word address, host-to-local direction |
| rd_stat_wdata | output | 32 | Status word, host-to-local direction |
| rd_stat_waitreq | input | 1 | Stall for the host-to-local status port |
| wr_stat_write | output | 1 | Status write request, local-to-host direction |
| wr_stat_addr | output | BASE_W | Status word address, local-to-host direction |
| wr_stat_wdata | output | 32 | Status word, local-to-host direction |
| wr_stat_waitreq | input | 1 | Stall for the local-to-host status port |
| irq | output | 1 | One-cycle interrupt request per finished descriptor |

## Verification
A wrong phase or index shows at the ports within one cycle. It can appear as a command on the wrong mover, a command index out of order, a status address that does not match the dispatched index, a missing or doubled interrupt, or the busy bit in word 0 disagreeing with activity on the command lines. A stuck error or direction flag shows the next time word 0 is read. A stall mishandled on the status port shows as the request dropping or its address changing while wait-request is high. The bench's model predicts every output on every cycle, so any such divergence is reported in the cycle it appears.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FETCH = 3'd1,
      PH_FWAIT = 3'd2,
      PH_MOVE  = 3'd3,
      PH_MWAIT = 3'd4,
      PH_STAT  = 3'd5,
      PH_IRQ   = 3'd6
   } phase_e;

   localparam logic [1:0] REG_CTRL    = 2'd0;
   localparam logic [1:0] REG_BASE_LO = 2'd1;
   localparam logic [1:0] REG_BASE_HI = 2'd2;
   localparam logic [1:0] REG_LAST    = 2'd3;

   localparam int CTL_START = 0;
   localparam int CTL_DIR   = 1;
   localparam int CTL_ERR   = 2;
   localparam int CTL_BUSY  = 3;

endpackage

// File: rtl/dds_regs.sv
`timescale 1ns/1ps
module dds_regs
   import dds_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int BASE_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_write,
   input  logic [1:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              busy,
   output logic [BASE_W-1:0] base,
   output logic [IDX_W-1:0]  last,
   output logic              dir,
   output logic              err,
   output logic              start
);

   localparam int HI_W = BASE_W - 32;

   logic wr_ctrl;

   assign wr_ctrl = csr_write && (csr_addr == REG_CTRL);
   assign start   = wr_ctrl && csr_wdata[CTL_START] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
         last <= '0;
         dir  <= 1'b0;
         err  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            if (csr_wdata[CTL_START] && busy) err <= 1'b1;
            else if (csr_wdata[CTL_ERR])      err <= 1'b0;
            if (!busy) dir <= csr_wdata[CTL_DIR];
         end
         if (csr_write && !busy) begin
            case (csr_addr)
               REG_BASE_LO: base[31:0]       <= csr_wdata;
               REG_BASE_HI: base[BASE_W-1:32] <= csr_wdata[HI_W-1:0];
               REG_LAST:    last              <= csr_wdata[IDX_W-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (csr_addr)
         REG_CTRL:    csr_rdata = {28'd0, busy, err, dir, 1'b0};
         REG_BASE_LO: csr_rdata = base[31:0];
         REG_BASE_HI: csr_rdata = 32'(base[BASE_W-1:32]);
         default:     csr_rdata = 32'(last);
      endcase
   end

endmodule

// File: rtl/dds_seq.sv
`timescale 1ns/1ps
module dds_seq
   import dds_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir,
   input  logic [IDX_W-1:0] last,
   input  logic             rd_done,
   input  logic             wr_done,
   input  logic             stat_accept,
   output phase_e           phase,
   output logic [IDX_W-1:0] idx
);

   phase_e           ph_nx;
   logic [IDX_W-1:0] idx_nx;
   logic             mv_done;

   assign mv_done = dir ? wr_done : rd_done;

   always_comb begin
      ph_nx  = phase;
      idx_nx = idx;
      case (phase)
         PH_IDLE:  if (start) begin ph_nx = PH_FETCH; idx_nx = '0; end
         PH_FETCH: ph_nx = PH_FWAIT;
         PH_FWAIT: if (rd_done) begin ph_nx = PH_MOVE; idx_nx = '0; end
         PH_MOVE:  ph_nx = PH_MWAIT;
         PH_MWAIT: if (mv_done) ph_nx = PH_STAT;
         PH_STAT:  if (stat_accept) ph_nx = PH_IRQ;
         PH_IRQ: begin
            if (idx == last) ph_nx = PH_IDLE;
            else begin
               ph_nx  = PH_MOVE;
               idx_nx = idx + 1'b1;
            end
         end
         default:  ph_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
      end else begin
         phase <= ph_nx;
         idx   <= idx_nx;
      end
   end

endmodule

// File: rtl/dds_stat_port.sv
`timescale 1ns/1ps
module dds_stat_port #(
   parameter int          IDX_W    = 8,
   parameter int          BASE_W   = 64,
   parameter logic [63:0] STAT_OFS = 64'h1000,
   parameter int          IS_WR    = 0
) (
   input  logic              active,
   input  logic [BASE_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic              waitreq,
   output logic              write,
   output logic [BASE_W-1:0] addr,
   output logic [31:0]       data,
   output logic              accept
);

   localparam logic DIR_BIT = (IS_WR != 0);

   logic [BASE_W-1:0] slot;

   assign slot   = base + STAT_OFS[BASE_W-1:0] + (BASE_W'(idx) << 2);
   assign write  = active;
   assign addr   = active ? slot : '0;
   assign data   = active ? {1'b1, DIR_BIT, 30'(idx)} : 32'd0;
   assign accept = active && !waitreq;

endmodule

// File: rtl/dma_desc_seq.sv
`timescale 1ns/1ps
module dma_desc_seq
   import dds_pkg::*;
#(
   parameter int          IDX_W    = 8,
   parameter int          BASE_W   = 64,
   parameter logic [63:0] STAT_OFS = 64'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_write,
   input  logic [1:0]        csr_addr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic [BASE_W-1:0] table_base,
   output logic              rd_cmd_valid,
   output logic              rd_cmd_fetch,
   output logic [IDX_W-1:0]  rd_cmd_index,
   input  logic              rd_done,
   output logic              wr_cmd_valid,
   output logic [IDX_W-1:0]  wr_cmd_index,
   input  logic              wr_done,
   output logic              rd_stat_write,
   output logic [BASE_W-1:0] rd_stat_addr,
   output logic [31:0]       rd_stat_wdata,
   input  logic              rd_stat_waitreq,
   output logic              wr_stat_write,
   output logic [BASE_W-1:0] wr_stat_addr,
   output logic [31:0]       wr_stat_wdata,
   input  logic              wr_stat_waitreq,
   output logic              irq
);

   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
      $error("dma_desc_seq: IDX_W must lie in 1..16");
   end
   if (BASE_W < 33 || BASE_W > 64) begin : g_bad_base
      $error("dma_desc_seq: BASE_W must lie in 33..64");
   end

   localparam int N_DIR = 2;

   phase_e            phase;
   logic [IDX_W-1:0]  idx;
   logic [BASE_W-1:0] base;
   logic [IDX_W-1:0]  last;
   logic              dir, err_flag, start, busy, stat_accept;

   logic [N_DIR-1:0]  sp_act, sp_wr, sp_acc, sp_wait;
   logic [BASE_W-1:0] sp_addr [N_DIR];
   logic [31:0]       sp_data [N_DIR];

   assign busy = (phase != PH_IDLE);

   dds_regs #(.IDX_W(IDX_W), .BASE_W(BASE_W)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .busy(busy),
      .base(base), .last(last), .dir(dir), .err(err_flag), .start(start)
   );

   dds_seq #(.IDX_W(IDX_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .last(last),
      .rd_done(rd_done), .wr_done(wr_done), .stat_accept(stat_accept),
      .phase(phase), .idx(idx)
   );

   assign sp_act  = {(phase == PH_STAT) && dir, (phase == PH_STAT) && !dir};
   assign sp_wait = {wr_stat_waitreq, rd_stat_waitreq};

   for (genvar g = 0; g < N_DIR; g++) begin : g_stat
      dds_stat_port #(
         .IDX_W(IDX_W), .BASE_W(BASE_W), .STAT_OFS(STAT_OFS), .IS_WR(g)
      ) i_port (
         .active(sp_act[g]), .base(base), .idx(idx), .waitreq(sp_wait[g]),
         .write(sp_wr[g]), .addr(sp_addr[g]), .data(sp_data[g]),
         .accept(sp_acc[g])
      );
   end

   assign stat_accept   = |sp_acc;

   assign rd_stat_write = sp_wr[0];
   assign rd_stat_addr  = sp_addr[0];
   assign rd_stat_wdata = sp_data[0];
   assign wr_stat_write = sp_wr[1];
   assign wr_stat_addr  = sp_addr[1];
   assign wr_stat_wdata = sp_data[1];

   assign table_base   = base;
   assign rd_cmd_fetch = (phase == PH_FETCH);
   assign rd_cmd_valid = (phase == PH_FETCH) || ((phase == PH_MOVE) && !dir);
   assign wr_cmd_valid = (phase == PH_MOVE) && dir;
   assign rd_cmd_index = idx;
   assign wr_cmd_index = idx;
   assign irq          = (phase == PH_IRQ);

endmodule

// File: rtl/dds_chk.sv
`timescale 1ns/1ps
module dds_chk #(
   parameter int BASE_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              err_flag,
   input logic              csr_write,
   input logic [1:0]        csr_addr,
   input logic              start_bit,
   input logic              rd_cmd_valid,
   input logic              rd_cmd_fetch,
   input logic              wr_cmd_valid,
   input logic              rd_stat_write,
   input logic [BASE_W-1:0] rd_stat_addr,
   input logic [31:0]       rd_stat_wdata,
   input logic              rd_stat_waitreq,
   input logic              wr_stat_write,
   input logic [BASE_W-1:0] wr_stat_addr,
   input logic [31:0]       wr_stat_wdata,
   input logic              wr_stat_waitreq,
   input logic              irq
);

   logic start_req, acc;

   assign start_req = csr_write && (csr_addr == 2'd0) && start_bit;
   assign acc = (rd_stat_write && !rd_stat_waitreq) || (wr_stat_write && !wr_stat_waitreq);

   AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && !busy |=> rd_cmd_valid && rd_cmd_fetch); // R2
   AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_cmd_valid, wr_cmd_valid})); // R3
   AST_RD_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd_valid |=> !rd_cmd_valid); // R3
   AST_WR_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd_valid |=> !wr_cmd_valid); // R3
   AST_RD_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat_write && rd_stat_waitreq |=>
         rd_stat_write && $stable(rd_stat_addr) && $stable(rd_stat_wdata)); // R5
   AST_WR_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat_write && wr_stat_waitreq |=>
         wr_stat_write && $stable(wr_stat_addr) && $stable(wr_stat_wdata)); // R5
   AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stat_write && wr_stat_write)); // R5
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7
   AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(acc)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(rd_cmd_valid || wr_cmd_valid || rd_stat_write || wr_stat_write || irq)); // R8
   AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && busy |=> err_flag); // R9

endmodule

bind dma_desc_seq dds_chk #(.BASE_W(BASE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .err_flag(err_flag),
   .csr_write(csr_write), .csr_addr(csr_addr), .start_bit(csr_wdata[0]),
   .rd_cmd_valid(rd_cmd_valid), .rd_cmd_fetch(rd_cmd_fetch), .wr_cmd_valid(wr_cmd_valid),
   .rd_stat_write(rd_stat_write), .rd_stat_addr(rd_stat_addr),
   .rd_stat_wdata(rd_stat_wdata), .rd_stat_waitreq(rd_stat_waitreq),
   .wr_stat_write(wr_stat_write), .wr_stat_addr(wr_stat_addr),
   .wr_stat_wdata(wr_stat_wdata), .wr_stat_waitreq(wr_stat_waitreq),
   .irq(irq)
);

// File: tb/test_dma_desc_seq.sv
`timescale 1ns/1ps
module test_dma_desc_seq;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 2;
   localparam longint unsigned OFS = 64'h1000;

   localparam int M_IDLE = 0, M_FETCH = 1, M_FWAIT = 2, M_MOVE = 3,
                  M_MWAIT = 4, M_STAT = 5, M_IRQ = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_write = 1'b0;
   logic [1:0]  csr_addr = 2'd0;
   logic [31:0] csr_wdata = 32'd0;
   logic [31:0] csr_rdata;
   logic [63:0] table_base;
   logic        rd_cmd_valid, rd_cmd_fetch, wr_cmd_valid;
   logic [7:0]  rd_cmd_index, wr_cmd_index;
   logic        rd_stat_write, wr_stat_write, irq;
   logic [63:0] rd_stat_addr, wr_stat_addr;
   logic [31:0] rd_stat_wdata, wr_stat_wdata;
   logic        rd_stat_waitreq = 1'b0, wr_stat_waitreq = 1'b0;
   logic        rd_done_r = 1'b0, wr_done_r = 1'b0;
   logic        sp_rd = 1'b0, sp_wr = 1'b0;
   wire         rd_done = rd_done_r | sp_rd;
   wire         wr_done = wr_done_r | sp_wr;

   int rd_lat = 1, wr_lat = 1, rd_stall_cfg = 0, wr_stall_cfg = 0;
   int rd_cnt = 0, wr_cnt = 0, rd_stall = 0, wr_stall = 0;

   int  n_chk = 0, n_fail = 0, irq_cnt = 0, cyc = 0;
   bit  run_chk = 0, finished = 0;
   longint unsigned acc_q [$];

   int m_ph = M_IDLE, m_idx = 0, m_last = 0;
   bit m_dir = 0, m_err = 0;
   longint unsigned m_base = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_desc_seq #(.IDX_W(8), .BASE_W(64), .STAT_OFS(64'h1000)) i_dma_desc_seq (
      .clk(clk), .rst_n(rst_n),
      .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .table_base(table_base),
      .rd_cmd_valid(rd_cmd_valid), .rd_cmd_fetch(rd_cmd_fetch), .rd_cmd_index(rd_cmd_index),
      .rd_done(rd_done),
      .wr_cmd_valid(wr_cmd_valid), .wr_cmd_index(wr_cmd_index), .wr_done(wr_done),
      .rd_stat_write(rd_stat_write), .rd_stat_addr(rd_stat_addr), .rd_stat_wdata(rd_stat_wdata),
      .rd_stat_waitreq(rd_stat_waitreq),
      .wr_stat_write(wr_stat_write), .wr_stat_addr(wr_stat_addr), .wr_stat_wdata(wr_stat_wdata),
      .wr_stat_waitreq(wr_stat_waitreq),
      .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model: advances on the clock edge from the inputs seen there
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = M_IDLE; m_idx = 0; m_last = 0; m_dir = 0; m_err = 0; m_base = 0;
      end else begin
         bit was_busy;
         was_busy = (m_ph != M_IDLE);
         if (csr_write) begin
            case (csr_addr)
               2'd0: begin
                  if (csr_wdata[0] && was_busy) m_err = 1;
                  else if (csr_wdata[2]) m_err = 0;
                  if (!was_busy) m_dir = csr_wdata[1];
               end
               2'd1: if (!was_busy) m_base[31:0] = csr_wdata;
               2'd2: if (!was_busy) m_base[63:32] = csr_wdata;
               default: if (!was_busy) m_last = int'(csr_wdata[7:0]);
            endcase
         end
         case (m_ph)
            M_IDLE:  if (csr_write && csr_addr == 2'd0 && csr_wdata[0]) begin m_ph = M_FETCH; m_idx = 0; end
            M_FETCH: m_ph = M_FWAIT;
            M_FWAIT: if (rd_done) begin m_ph = M_MOVE; m_idx = 0; end
            M_MOVE:  m_ph = M_MWAIT;
            M_MWAIT: if (m_dir ? wr_done : rd_done) m_ph = M_STAT;
            M_STAT:  if (!(m_dir ? wr_stat_waitreq : rd_stat_waitreq)) m_ph = M_IRQ;
            default: begin
               if (m_idx == m_last) m_ph = M_IDLE;
               else begin m_idx++; m_ph = M_MOVE; end
            end
         endcase
      end
   end

   // per-cycle comparison, away from the edges
   always @(negedge clk) begin
      #(Q);
      if (rst_n && run_chk) begin
         bit e_busy;
         longint unsigned e_slot, e_rd;
         e_busy = (m_ph != M_IDLE);
         e_slot = m_base + OFS + 4 * longint'(m_idx);
         case (csr_addr)
            2'd0: e_rd = {28'd0, e_busy, m_err, m_dir, 1'b0};
            2'd1: e_rd = m_base[31:0];
            2'd2: e_rd = m_base[63:32];
            default: e_rd = longint'(m_last);
         endcase
         chk(csr_rdata == e_rd[31:0], "R1", "csr_rdata", csr_rdata, e_rd);
         chk(table_base == m_base, "R1", "table_base", table_base, m_base);
         chk(rd_cmd_valid == ((m_ph == M_FETCH) || (m_ph == M_MOVE && !m_dir)), "R3", "rd_cmd_valid", rd_cmd_valid, 0);
         chk(rd_cmd_fetch == (m_ph == M_FETCH), "R2", "rd_cmd_fetch", rd_cmd_fetch, m_ph == M_FETCH);
         chk(wr_cmd_valid == (m_ph == M_MOVE && m_dir), "R3", "wr_cmd_valid", wr_cmd_valid, m_ph == M_MOVE && m_dir);
         if (m_ph == M_MOVE)
            chk((m_dir ? wr_cmd_index : rd_cmd_index) == m_idx[7:0], "R3", "cmd_index",
                m_dir ? wr_cmd_index : rd_cmd_index, m_idx);
         chk(rd_stat_write == (m_ph == M_STAT && !m_dir), "R5", "rd_stat_write", rd_stat_write, 0);
         chk(wr_stat_write == (m_ph == M_STAT && m_dir), "R5", "wr_stat_write", wr_stat_write, 0);
         if (m_ph == M_STAT) begin
            longint unsigned e_word;
            e_word = 64'h8000_0000 | (longint'(m_dir) << 30) | longint'(m_idx);
            chk((m_dir ? wr_stat_addr : rd_stat_addr) == e_slot, "R5", "stat_addr",
                m_dir ? wr_stat_addr : rd_stat_addr, e_slot);
            chk((m_dir ? wr_stat_wdata : rd_stat_wdata) == e_word[31:0], "R5", "stat_wdata",
                m_dir ? wr_stat_wdata : rd_stat_wdata, e_word);
         end
         chk(irq == (m_ph == M_IRQ), "R7", "irq", irq, m_ph == M_IRQ);
         if (rd_stat_write && !rd_stat_waitreq) acc_q.push_back(rd_stat_addr);
         if (wr_stat_write && !wr_stat_waitreq) acc_q.push_back(wr_stat_addr);
         if (irq) irq_cnt++;
      end
   end

   // mover and status-port responders
   always @(negedge clk) begin
      rd_done_r = 1'b0;
      wr_done_r = 1'b0;
      if (rd_cnt > 0) begin rd_cnt--; if (rd_cnt == 0) rd_done_r = 1'b1; end
      if (wr_cnt > 0) begin wr_cnt--; if (wr_cnt == 0) wr_done_r = 1'b1; end
      if (rd_cmd_valid) rd_cnt = rd_lat;
      if (wr_cmd_valid) wr_cnt = wr_lat;
      if (rd_stat_write && rd_stall > 0) begin rd_stat_waitreq = 1'b1; rd_stall--; end
      else begin rd_stat_waitreq = 1'b0; if (!rd_stat_write) rd_stall = rd_stall_cfg; end
      if (wr_stat_write && wr_stall > 0) begin wr_stat_waitreq = 1'b1; wr_stall--; end
      else begin wr_stat_waitreq = 1'b0; if (!wr_stat_write) wr_stall = wr_stall_cfg; end
   end

   task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_write = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_write = 1'b0; csr_wdata = 32'd0;
   endtask

   task automatic csr_rd(input logic [1:0] a, input logic [31:0] e, input string req);
      @(negedge clk);
      csr_addr = a;
      #(Q + 1);
      chk(csr_rdata == e, req, "register read", csr_rdata, e);
   endtask

   task automatic wait_idle;
      @(negedge clk);
      csr_addr = 2'd0;
      do begin @(negedge clk); #(Q + 1); end while (csr_rdata[3]);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run_chk = 1;

      // R10: reset state
      csr_rd(2'd0, 32'd0, "R10");
      csr_rd(2'd1, 32'd0, "R10");
      csr_rd(2'd3, 32'd0, "R10");
      chk(!rd_cmd_valid && !wr_cmd_valid && !irq, "R10", "outputs idle", irq, 0);

      // R1 R2 R3 R6: host-to-local run of three descriptors
      csr_wr(2'd1, 32'h9ABC_DE00);
      csr_wr(2'd2, 32'h1234_5678);
      csr_wr(2'd3, 32'd2);
      csr_rd(2'd2, 32'h1234_5678, "R1");
      rd_lat = 2; rd_stall_cfg = 1;
      acc_q.delete(); irq_cnt = 0;
      csr_wr(2'd0, 32'h1);
      csr_rd(2'd0, 32'h8, "R8");
      wait_idle();
      chk(irq_cnt == 3, "R7", "irq count", irq_cnt, 3);
      chk(acc_q.size() == 3, "R6", "status writes", acc_q.size(), 3);
      for (int i = 0; i < 3 && i < acc_q.size(); i++)
         chk(acc_q[i] == 64'h1234_5678_9ABC_DE00 + OFS + 4 * i, "R6", "status order",
             acc_q[i], 64'h1234_5678_9ABC_DE00 + OFS + 4 * i);

      // R4 R5 R9: local-to-host run with stalls, stray done, busy writes
      csr_wr(2'd1, 32'h0000_4000);
      csr_wr(2'd2, 32'h0);
      csr_wr(2'd3, 32'd3);
      wr_lat = 4; wr_stall_cfg = 3;
      acc_q.delete(); irq_cnt = 0;
      csr_wr(2'd0, 32'h3);
      while (irq_cnt < 1) @(negedge clk);
      @(negedge clk); sp_rd = 1'b1;
      @(negedge clk); sp_rd = 1'b0;
      csr_wr(2'd0, 32'h1);
      csr_wr(2'd1, 32'hFFFF_0000);
      csr_wr(2'd3, 32'd9);
      wait_idle();
      chk(irq_cnt == 4, "R4", "irq count with stray done", irq_cnt, 4);
      chk(acc_q.size() == 4, "R5", "status writes", acc_q.size(), 4);
      for (int i = 0; i < 4 && i < acc_q.size(); i++)
         chk(acc_q[i] == 64'h4000 + OFS + 4 * i, "R5", "status order", acc_q[i], 64'h4000 + OFS + 4 * i);
      csr_rd(2'd0, 32'h6, "R9");
      csr_rd(2'd1, 32'h0000_4000, "R9");
      csr_rd(2'd3, 32'd3, "R9");
      csr_wr(2'd0, 32'h4);
      csr_rd(2'd0, 32'h0, "R9");

      // R4 R8: stray done pulses while idle
      @(negedge clk); sp_rd = 1'b1; sp_wr = 1'b1;
      @(negedge clk); sp_rd = 1'b0; sp_wr = 1'b0;
      repeat (3) @(negedge clk);
      csr_rd(2'd0, 32'h0, "R8");

      // R10: reset in the middle of a run
      csr_wr(2'd3, 32'd5);
      rd_lat = 1; rd_stall_cfg = 0; irq_cnt = 0;
      csr_wr(2'd0, 32'h1);
      while (irq_cnt < 2) @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #(Q);
      chk(!rd_cmd_valid && !wr_cmd_valid && !rd_stat_write && !irq, "R10", "outputs in reset", irq, 0);
      chk(csr_rdata == 32'd0 || csr_addr != 2'd0, "R10", "ctrl in reset", csr_rdata, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      csr_rd(2'd1, 32'd0, "R10");
      csr_rd(2'd3, 32'd0, "R10");
      csr_rd(2'd0, 32'd0, "R10");

      repeat (5) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

endmodule